// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller sits between an SRAM port and the shadow nonvolatile array behind it. It decides when the SRAM contents are copied into nonvolatile cells (a store) and when they are copied back (a recall). It also gates SRAM access while either transfer is pending or running. Two digital flags from a supply monitor drive it: one says the supply is below the reset level, the other says it is above the switch level. Any time the supply drops under the reset level, a recall is armed. That recall starts by itself once the supply is back above the switch level.

A shared active-low handshake line carries store requests. The line is resolved as a wired-AND. The block only ever pulls it low, through an output enable, and it watches the resolved level through a two-flop synchronizer. When the line goes low, the block waits a fixed request delay. It then runs a store only if a write was accepted since the last store or recall. While the store runs, the block pulls the line low itself. This lets one requester trigger stores in every device on the line and hold them until all are finished. After a store, the SRAM stays disabled until the line is seen high again.

The block has no data stream. All pins are plain level controls, so there is no valid/ready handshake and no back-pressure. A read or write request is either granted in the same cycle or refused.

Top module: `nvseq_ctrl`

## Requirements
- R1: During reset, and in any cycle where `pwr_below_reset` is high, the SRAM is disabled (`sram_en`=0) and no transfer runs. While `pwr_above_switch` stays low after that, no recall starts.
- R2: Suppose the block is powered down and sees `pwr_below_reset`=0 and `pwr_above_switch`=1 at a clock edge. From that edge on, `nv_recall_run` is high for exactly RECALL_CYC cycles. The SRAM stays disabled during that time and is enabled right after.
- R3: `pwr_below_reset` high at an edge aborts any store or recall in progress and disables the SRAM from that edge on. The dirty flag is left unchanged, and a new recall is armed.
- R4: The handshake line is sampled by a two-flop synchronizer. When the line is driven low at the port while the block is idle, a store (if one is due) begins at the DELAY_CYC+3rd rising edge after the line went low.
- R5: A store runs only if the dirty flag is set when the request delay ends. If it is clear, no nonvolatile cycle runs and reads stay granted.
- R6: Reads are granted throughout the request delay. A write that was granted in the previous cycle stays granted for as long as its request is held, up to the start of a store.
- R7: A write is refused at its first cycle if, in that cycle, the synchronized line is low, or the request delay is running, or the block is waiting for the line to return high. Because of the synchronizer, a write that starts in either of the first two cycles after the line falls at the port is still accepted.
- R8: A store keeps `nv_store_run` and `hs_pull_oe` high for exactly STORE_CYC cycles. The SRAM is disabled for that whole time.
- R9: After a store, the SRAM stays disabled while the line is low. It is enabled at the third rising edge after the line returns high at the port.
- R10: `nv_dirty` is set by any granted write. It is cleared when a store or a recall completes. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_below_reset | input | 1 | Supply monitor: supply under reset level |
| pwr_above_switch | input | 1 | Supply monitor: supply over switch level |
| hs_line_in | input | 1 | Resolved level of the shared handshake line |
| hs_pull_oe | output | 1 | Pull the shared line low (never drives high) |
| sram_rd_req | input | 1 | SRAM read cycle requested |
| sram_wr_req | input | 1 | SRAM write cycle requested |
| sram_en | output | 1 | SRAM port enabled |
| sram_rd_en | output | 1 | Read granted this cycle |
| sram_wr_en | output | 1 | Write granted this cycle |
| nv_store_run | output | 1 | Store engine running |
| nv_recall_run | output | 1 | Recall engine running |
| nv_dirty | output | 1 | A write was accepted since the last store or recall |

## Verification
The hardest case to reach from the ports is a write whose first cycle falls close to the handshake fall, where the synchronizer latency decides between acceptance and refusal. The bench sweeps the write's start offset across every cycle from the line fall to the start of the store. It does this once with the array already dirty and once with it clean. For each offset it predicts the grant, whether a store happens, its start cycle and its length. The bench resolves the line as a wired-AND of its own pull and the block's pull, so the lock after a store is exercised with the line held low externally. A supply drop is injected in the middle of a store.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    ST_PWRDN  = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_DELAY  = 3'd3,
    ST_HOLD   = 3'd4,
    ST_STORE  = 3'd5,
    ST_LOCK   = 3'd6
  } nv_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
#(
  parameter int DELAY_CYC  = 16,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 32,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          below_rst,
  input  logic          above_sw,
  input  logic          line_s,
  input  logic          dirty,
  input  logic          tmr_zero,
  output nv_state_e     state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          store_done,
  output logic          recall_done
);
  nv_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    store_done  = 1'b0;
    recall_done = 1'b0;
    if (below_rst) begin
      state_d = ST_PWRDN;
    end else begin
      unique case (state_q)
        ST_PWRDN: if (above_sw) begin
          state_d  = ST_RECALL;
          tmr_load = 1'b1;
          tmr_val  = CW'(RECALL_CYC - 1);
        end
        ST_RECALL: if (tmr_zero) begin
          state_d     = ST_IDLE;
          recall_done = 1'b1;
        end
        ST_IDLE: if (!line_s) begin
          state_d  = ST_DELAY;
          tmr_load = 1'b1;
          tmr_val  = CW'(DELAY_CYC - 1);
        end
        ST_DELAY: if (tmr_zero) begin
          if (dirty) begin
            state_d  = ST_STORE;
            tmr_load = 1'b1;
            tmr_val  = CW'(STORE_CYC - 1);
          end else begin
            state_d = ST_HOLD;
          end
        end
        ST_HOLD:  if (line_s) state_d = ST_IDLE;
        ST_STORE: if (tmr_zero) begin
          state_d    = ST_LOCK;
          store_done = 1'b1;
        end
        ST_LOCK:  if (line_s) state_d = ST_IDLE;
        default:  state_d = ST_PWRDN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_PWRDN;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/nvseq_gate.sv
module nvseq_gate
  import nvseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  nv_state_e state,
  input  logic      line_s,
  input  logic      rd_req,
  input  logic      wr_req,
  output logic      port_en,
  output logic      rd_en,
  output logic      wr_en
);
  logic wr_prev_q;
  logic new_wr_block;

  assign port_en = (state == ST_IDLE) || (state == ST_DELAY) || (state == ST_HOLD);
  assign new_wr_block = !line_s || (state == ST_DELAY) || (state == ST_HOLD);
  assign rd_en = rd_req && port_en;
  assign wr_en = wr_req && port_en && (!new_wr_block || wr_prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_en;
  end
endmodule

// File: rtl/nvseq_dirty.sv
module nvseq_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (clr_i) flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
  end
endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int DELAY_CYC   = 16,
  parameter int STORE_CYC   = 64,
  parameter int RECALL_CYC  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_below_reset,
  input  logic pwr_above_switch,
  input  logic hs_line_in,
  output logic hs_pull_oe,
  input  logic sram_rd_req,
  input  logic sram_wr_req,
  output logic sram_en,
  output logic sram_rd_en,
  output logic sram_wr_en,
  output logic nv_store_run,
  output logic nv_recall_run,
  output logic nv_dirty
);
  localparam int MAXC = max3(DELAY_CYC, STORE_CYC, RECALL_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          line_s;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          store_done, recall_done;
  nv_state_e     state;

  nvseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(hs_line_in), .d_out(line_s)
  );

  nvseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  nvseq_fsm #(
    .DELAY_CYC(DELAY_CYC), .STORE_CYC(STORE_CYC),
    .RECALL_CYC(RECALL_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .below_rst(pwr_below_reset), .above_sw(pwr_above_switch),
    .line_s(line_s), .dirty(nv_dirty), .tmr_zero(tmr_zero),
    .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .store_done(store_done), .recall_done(recall_done)
  );

  nvseq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .line_s(line_s),
    .rd_req(sram_rd_req), .wr_req(sram_wr_req),
    .port_en(sram_en), .rd_en(sram_rd_en), .wr_en(sram_wr_en)
  );

  nvseq_dirty u_dirty (
    .clk(clk), .rst_n(rst_n),
    .set_i(sram_wr_en), .clr_i(store_done || recall_done),
    .flag(nv_dirty)
  );

  assign nv_store_run  = (state == ST_STORE);
  assign nv_recall_run = (state == ST_RECALL);
  assign hs_pull_oe    = nv_store_run;
endmodule

// File: rtl/nvseq_ctrl_chk.sv
module nvseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_below_reset,
  input logic hs_pull_oe,
  input logic sram_en,
  input logic sram_rd_en,
  input logic sram_wr_en,
  input logic nv_store_run,
  input logic nv_recall_run,
  input logic nv_dirty
);
  AST_BELOW_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_below_reset |=> (!sram_en && !nv_store_run && !nv_recall_run)); // R3

  AST_NO_ACCESS_IN_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_store_run || nv_recall_run) |-> (!sram_wr_en && !sram_rd_en)); // R8

  AST_PULL_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pull_oe |-> !sram_en); // R8

  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_store_run) |-> $past(nv_dirty)); // R5

  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |=> nv_dirty); // R10

  AST_RECALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nv_recall_run) && sram_en) |-> !nv_dirty); // R10

  AST_TRANSFERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_store_run && nv_recall_run)); // R2
endmodule

bind nvseq_ctrl nvseq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_below_reset(pwr_below_reset),
  .hs_pull_oe(hs_pull_oe), .sram_en(sram_en), .sram_rd_en(sram_rd_en),
  .sram_wr_en(sram_wr_en), .nv_store_run(nv_store_run),
  .nv_recall_run(nv_recall_run), .nv_dirty(nv_dirty)
);

// File: tb/nvseq_ctrl_test.sv
module nvseq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int D = 3;
  localparam int S = 4;
  localparam int R = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below = 1'b1, above = 1'b0;
  logic ext_pull = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic hs_line, pull_oe, sram_en, rd_en, wr_en, store_run, recall_run, dirty;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND of the external requester and the device
  assign hs_line = !(ext_pull || pull_oe);

  nvseq_ctrl #(.DELAY_CYC(D), .STORE_CYC(S), .RECALL_CYC(R), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_below_reset(below), .pwr_above_switch(above),
    .hs_line_in(hs_line), .hs_pull_oe(pull_oe),
    .sram_rd_req(rd_req), .sram_wr_req(wr_req),
    .sram_en(sram_en), .sram_rd_en(rd_en), .sram_wr_en(wr_en),
    .nv_store_run(store_run), .nv_recall_run(recall_run), .nv_dirty(dirty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one granted single-cycle write, then idle
  task automatic do_write();
    wr_req = 1'b1;
    #1;
    chk("R10 write grant", int'(wr_en), 1);
    step();
    wr_req = 1'b0;
    chk("R10 dirty set", int'(dirty), 1);
  endtask

  task automatic wait_en();
    for (int i = 0; i < 50 && !sram_en; i++) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    @(negedge clk);
    step();
    // R1: reset state
    chk("R1 en in reset", int'(sram_en), 0);
    chk("R1 dirty in reset", int'(dirty), 0);
    chk("R1 pull in reset", int'(pull_oe), 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 no recall below", int'(recall_run), 0);
    below = 1'b0;
    repeat (3) step();
    chk("R1 no recall w/o switch", int'(recall_run), 0);
    chk("R1 en powered down", int'(sram_en), 0);

    // R2: recall timing
    above = 1'b1;
    cnt = 0;
    while (!recall_run && cnt < 20) begin step(); cnt++; end
    chk("R2 recall start", cnt, 1);
    cnt = 0;
    while (recall_run && cnt < 20) begin
      chk("R2 en during recall", int'(sram_en), 0);
      step(); cnt++;
    end
    chk("R2 recall length", cnt, R);
    chk("R2 en after recall", int'(sram_en), 1);
    chk("R10 dirty after recall", int'(dirty), 0);

    // R4-R7 sweep: write start offset x prior dirty state
    for (int pre = 0; pre < 2; pre++) begin
      for (int off = 0; off <= D + 3; off++) begin
        int start, len;
        bit exp_store, exp_grant;
        if (pre == 1) do_write();
        exp_grant = (off < 2);
        exp_store = (pre == 1) || exp_grant;
        start = -1; len = 0;
        rd_req = 1'b1;
        for (int c = 0; c < D + S + 10; c++) begin
          ext_pull = (c < 2);
          wr_req = (c == off);
          #1;
          if (c == off)
            chk(exp_grant ? "R7 early write granted" : "R7 late write refused",
                int'(wr_en), int'(exp_grant));
          if (c < D + 3) chk("R6 read in delay", int'(rd_en), 1);
          if (pull_oe) begin
            if (start < 0) start = c;
            len++;
            chk("R8 en off in store", int'(sram_en), 0);
          end
          step();
        end
        wr_req = 1'b0;
        rd_req = 1'b0;
        wait_en();
        if (exp_store) begin
          chk("R4 store start cycle", start, D + 3);
          chk("R8 store length", len, S);
        end else begin
          chk("R5 no store when clean", start, -1);
        end
        chk("R10 dirty after sweep run", int'(dirty), 0);
      end
    end

    // R6: write in progress continues through the delay
    wr_req = 1'b1;
    step();
    for (int c = 0; c <= D + 3; c++) begin
      ext_pull = 1'b1;
      #1;
      if (c == D + 2) chk("R6 ongoing write kept", int'(wr_en), 1);
      if (c == D + 3) chk("R8 write stopped by store", int'(wr_en), 0);
      step();
    end
    wr_req = 1'b0;

    // R9: lock held while line low externally
    cnt = 0;
    while (pull_oe && cnt < 20) begin step(); cnt++; end
    repeat (4) begin
      chk("R9 locked while line low", int'(sram_en), 0);
      step();
    end
    ext_pull = 1'b0;
    cnt = 0;
    while (!sram_en && cnt < 20) begin step(); cnt++; end
    chk("R9 unlock latency", cnt, 3);

    // R3: supply drop during a store
    do_write();
    ext_pull = 1'b1;
    cnt = 0;
    while (!pull_oe && cnt < 20) begin step(); cnt++; end
    ext_pull = 1'b0;
    step();
    below = 1'b1;
    above = 1'b0;
    step();
    chk("R3 store aborted", int'(store_run), 0);
    chk("R3 en off", int'(sram_en), 0);
    chk("R3 dirty kept", int'(dirty), 1);
    below = 1'b0;
    above = 1'b1;
    cnt = 0;
    while (!recall_run && cnt < 20) begin step(); cnt++; end
    chk("R3 recall re-armed", cnt, 1);
    wait_en();
    chk("R10 recall clears dirty", int'(dirty), 0);
    chk("R2 en after second recall", int'(sram_en), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule